// File: doc/BRIEF.md
# Exception Entry and Interrupt Mask Controller

This block works next to the instruction decoder of a small CPU. It decides when an exception starts, and it keeps the two mask flags of the condition code register: the nonmaskable mask `mask_x` and the maskable mask `mask_i`. It handles four sources. An unimplemented second-page opcode raises a trap. A software-interrupt instruction raises an exception of its own. There is also a nonmaskable request line and a maskable request line. For each exception taken it reports the source, the vector address and the return address that the stacking logic must push. After the decoder reports that stacking is complete, it updates the masks. On a return-from-interrupt it restores the masks from a small shadow stack.

The decoder asserts `insn_valid` at each instruction boundary. It presents the page flag and code of the next opcode, a flag for the software-interrupt opcode, the address of the instruction, and the address that follows its opcode. Register stacking, the memory bus and the rest of the instruction set stay outside the block. The only link to them is the `take` / `stack_done` handshake and the `rti` and `ccr_wr` strobes.

Top module: `exc_ctl`

## Requirements
- R1: After reset, `mask_x` and `mask_i` are both 1, and `take` and `busy` are both 0.
- R2: A second-page code (`insn_p2`=1) is valid exactly when the code is a multiple of 5, or when it is 1 or 2. That makes 54 valid codes. Any other second-page code raises a trap with `take_kind`=0, vector 0xFFF8 and return address `insn_next_pc`.
- R3: When several sources are pending at one boundary, only one is taken. The order is trap, then software interrupt, then nonmaskable, then maskable.
- R4: The software-interrupt opcode is taken whatever the values of `mask_x` and `mask_i`. It reports `take_kind`=1, vector 0xFFF6 and return address `insn_next_pc`.
- R5: `nmi_req` is accepted only while `mask_x`=0. It reports `take_kind`=2, vector 0xFFF4 and return address `insn_pc`. Both masks are set to 1 only on `stack_done`, and not earlier.
- R6: `irq_req` is accepted only while `mask_i`=0. It reports `take_kind`=3, vector 0xFFF2 and return address `insn_pc`. On `stack_done` it sets `mask_i` and leaves `mask_x` unchanged.
- R7: `take` is a one-cycle pulse in the cycle after the boundary. `busy` then stays high until `stack_done`, and no further exception is taken while `busy` is high. A boundary that coincides with `rti` or `ccr_wr` is not a take point.
- R8: A software write (`ccr_wr`) loads `mask_i` from `ccr_wi`. It can clear `mask_x` but can never set it. Writes made while `busy` is high have no effect.
- R9: `rti` restores both masks to the values they held when the most recent unreturned exception was taken. Up to two nested exceptions are tracked. An `rti` with nothing saved leaves the masks unchanged.
- R10: A trap or a software interrupt sets `mask_i` on `stack_done` and leaves `mask_x` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_valid | input | 1 | Instruction boundary strobe |
| insn_p2 | input | 1 | The opcode at the boundary is a second-page opcode |
| insn_code | input | 8 | Second-page opcode byte |
| insn_swi | input | 1 | The opcode at the boundary is the software-interrupt instruction |
| insn_pc | input | 16 | Address of the instruction at the boundary |
| insn_next_pc | input | 16 | Address just past that instruction's opcode |
| nmi_req | input | 1 | Nonmaskable request level |
| irq_req | input | 1 | Maskable request level |
| stack_done | input | 1 | Register stacking has finished |
| rti | input | 1 | Return-from-interrupt executed |
| ccr_wr | input | 1 | Software write to the mask flags |
| ccr_wx | input | 1 | Written value for the nonmaskable mask |
| ccr_wi | input | 1 | Written value for the maskable mask |
| take | output | 1 | One-cycle exception start pulse |
| take_kind | output | 2 | Source taken: 0 trap, 1 software, 2 nonmaskable, 3 maskable |
| vec_addr | output | 16 | Vector address of the exception taken |
| ret_addr | output | 16 | Return address to push |
| busy | output | 1 | Exception taken, stacking not yet complete |
| mask_x | output | 1 | Nonmaskable mask flag |
| mask_i | output | 1 | Maskable mask flag |

## Verification
The bench nests a nonmaskable entry inside a maskable service and then unwinds it with three returns. A shadow stack that restored in the wrong order, or did not ignore the extra return, would leave the maskable mask set or lose the saved state. It sweeps all 256 second-page codes and expects exactly 202 traps, each returning past the opcode. A wrong validity table or a return to the instruction address would show up there. It also stacks every source at one boundary to expose a wrong priority. It attempts to set the nonmaskable mask from software, and a writable mask would block later nonmaskable requests. It also samples the masks between `take` and `stack_done`, where a design that set them early would fail.

// File: rtl/exc_pkg.sv
// Shared types and default tables for the exception entry controller.
package exc_pkg;

    typedef enum logic [1:0] {
        EXC_TRAP = 2'd0,
        EXC_SWI  = 2'd1,
        EXC_NMI  = 2'd2,
        EXC_IRQ  = 2'd3
    } exc_kind_e;

    // Default set of implemented second-page codes: multiples of 5 plus 1 and 2 (54 codes).
    function automatic logic [255:0] p2_default_mask();
        logic [255:0] m;
        m = '0;
        for (int c = 0; c < 256; c++) begin
            m[c] = ((c % 5) == 0) || (c == 1) || (c == 2);
        end
        return m;
    endfunction

endpackage

// File: rtl/exc_p2_check.sv
// Flags a second-page opcode whose code is not in the implemented set.
// Assumes: code is only meaningful while is_p2 is high; purely combinational.
module exc_p2_check #(
    parameter int          CODE_W = 8,
    parameter logic [255:0] VALID = exc_pkg::p2_default_mask()
) (
    input  logic              is_p2,
    input  logic [CODE_W-1:0] code,
    output logic              bad
);
    localparam int N_CODES = 1 << CODE_W;

    logic [N_CODES-1:0] valid_tab;

    // Trim the table to the code space.
    assign valid_tab = VALID[N_CODES-1:0];

    // Unimplemented when on page 2 and the table bit is clear.
    always_comb begin
        bad = is_p2 && !valid_tab[code];
    end
endmodule

// File: rtl/exc_arb.sv
// Fixed-priority selector: request index 0 wins, then 1, and so on.
// Assumes: requests are already qualified by their masks; purely combinational.
module exc_arb #(
    parameter int N = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    // Accumulate "some higher-priority request is present" down the chain.
    for (genvar g = 0; g < N; g++) begin : g_chain
        assign seen[g+1] = seen[g] | req[g];
    end

    assign any = seen[N];

    // Encode the lowest set index.
    always_comb begin
        idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) idx = IDX_W'(k);
        end
    end
endmodule

// File: rtl/exc_shadow.sv
// Small LIFO of saved mask pairs; pushing when full discards the oldest entry.
// Assumes: push and pop are never asserted together; pop on empty is ignored.
module exc_shadow #(
    parameter int DEPTH = 2,
    parameter int W     = 2,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] top,
    output logic         nonempty
);
    logic [W-1:0] ent [DEPTH];
    logic [CNT_W-1:0] cnt;

    assign top      = ent[0];
    assign nonempty = (cnt != '0);

    // Occupancy counter, saturating at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else if (push && cnt != CNT_W'(DEPTH)) cnt <= cnt + 1'b1;
        else if (pop && nonempty) cnt <= cnt - 1'b1;
    end

    // Entry 0 is the head: it is loaded on push and refilled from entry 1 on pop.
    always_ff @(posedge clk) begin
        if (!rst_n) ent[0] <= '0;
        else if (push) ent[0] <= push_data;
        else if (pop && nonempty) ent[0] <= (DEPTH > 1) ? ent[1 % DEPTH] : '0;
    end

    // Deeper entries shift down on push and up on pop.
    for (genvar g = 1; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) ent[g] <= '0;
            else if (push) ent[g] <= ent[g-1];
            else if (pop && nonempty) ent[g] <= (g + 1 < DEPTH) ? ent[(g + 1) % DEPTH] : '0;
        end
    end
endmodule

// File: rtl/exc_ctl.sv
// Exception entry and interrupt mask controller.
// At each instruction boundary it picks at most one exception (trap, software,
// nonmaskable, maskable), registers its vector and return address, and waits
// for stack_done before updating the masks. rti restores masks from a shadow stack.
// Assumes: rti and ccr_wr are one-cycle strobes from the decoder; stack_done
// arrives only while busy.
module exc_ctl #(
    parameter int           ADDR_W       = 16,
    parameter int           SHADOW_DEPTH = 2,
    parameter logic [255:0] P2_VALID     = exc_pkg::p2_default_mask(),
    parameter logic [ADDR_W-1:0] VEC_TRAP = 16'hFFF8,
    parameter logic [ADDR_W-1:0] VEC_SWI  = 16'hFFF6,
    parameter logic [ADDR_W-1:0] VEC_NMI  = 16'hFFF4,
    parameter logic [ADDR_W-1:0] VEC_IRQ  = 16'hFFF2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_valid,
    input  logic              insn_p2,
    input  logic [7:0]        insn_code,
    input  logic              insn_swi,
    input  logic [ADDR_W-1:0] insn_pc,
    input  logic [ADDR_W-1:0] insn_next_pc,
    input  logic              nmi_req,
    input  logic              irq_req,
    input  logic              stack_done,
    input  logic              rti,
    input  logic              ccr_wr,
    input  logic              ccr_wx,
    input  logic              ccr_wi,
    output logic              take,
    output logic [1:0]        take_kind,
    output logic [ADDR_W-1:0] vec_addr,
    output logic [ADDR_W-1:0] ret_addr,
    output logic              busy,
    output logic              mask_x,
    output logic              mask_i
);
    import exc_pkg::*;

    localparam int N_SRC = 4;
    localparam int IDX_W = $clog2(N_SRC);

    logic             bad_op;
    logic [N_SRC-1:0] src_req;
    logic             src_any;
    logic [IDX_W-1:0] src_idx;
    logic             start;
    logic             ctrl_ok;
    logic [1:0]       shadow_top;
    logic             shadow_ne;
    logic             do_pop;
    exc_kind_e        kind_sel;
    logic [ADDR_W-1:0] vec_sel;
    logic [ADDR_W-1:0] ret_sel;

    exc_p2_check #(.CODE_W(8), .VALID(P2_VALID)) u_p2 (
        .is_p2 (insn_p2),
        .code  (insn_code),
        .bad   (bad_op)
    );

    // Qualify each source with its mask; index order is the priority order.
    always_comb begin
        src_req[EXC_TRAP] = bad_op;
        src_req[EXC_SWI]  = insn_swi && !insn_p2;
        src_req[EXC_NMI]  = nmi_req && !mask_x;
        src_req[EXC_IRQ]  = irq_req && !mask_i;
    end

    exc_arb #(.N(N_SRC)) u_arb (
        .req (src_req),
        .any (src_any),
        .idx (src_idx)
    );

    // A take point is a boundary while idle and free of control strobes.
    assign start   = insn_valid && !busy && src_any && !rti && !ccr_wr;
    assign ctrl_ok = !busy;
    assign do_pop  = ctrl_ok && rti && shadow_ne;

    // Map the winning source to its vector and return address.
    always_comb begin
        kind_sel = exc_kind_e'(src_idx);
        case (kind_sel)
            EXC_TRAP: vec_sel = VEC_TRAP;
            EXC_SWI:  vec_sel = VEC_SWI;
            EXC_NMI:  vec_sel = VEC_NMI;
            default:  vec_sel = VEC_IRQ;
        endcase
        ret_sel = (kind_sel == EXC_TRAP || kind_sel == EXC_SWI) ? insn_next_pc : insn_pc;
    end

    exc_shadow #(.DEPTH(SHADOW_DEPTH), .W(2)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (start),
        .push_data ({mask_x, mask_i}),
        .pop       (do_pop),
        .top       (shadow_top),
        .nonempty  (shadow_ne)
    );

    // Entry pulse and the registered description of the exception taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take      <= 1'b0;
            take_kind <= 2'd0;
            vec_addr  <= '0;
            ret_addr  <= '0;
        end else begin
            take <= start;
            if (start) begin
                take_kind <= kind_sel;
                vec_addr  <= vec_sel;
                ret_addr  <= ret_sel;
            end
        end
    end

    // Busy from entry until stacking completes.
    always_ff @(posedge clk) begin
        if (!rst_n) busy <= 1'b0;
        else if (start) busy <= 1'b1;
        else if (stack_done) busy <= 1'b0;
    end

    // Mask flags: set after stacking, restored by rti, X only clearable by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_x <= 1'b1;
            mask_i <= 1'b1;
        end else if (busy && stack_done) begin
            mask_i <= 1'b1;
            if (take_kind == EXC_NMI) mask_x <= 1'b1;
        end else if (do_pop) begin
            mask_x <= shadow_top[1];
            mask_i <= shadow_top[0];
        end else if (ctrl_ok && ccr_wr && !rti) begin
            mask_x <= mask_x & ccr_wx;
            mask_i <= ccr_wi;
        end
    end
endmodule

// File: rtl/exc_ctl_chk.sv
// Property checker for exc_ctl; attached through bind below.
// Keeps its own two-deep record of masks seen at each entry to check restores.
module exc_ctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        take,
    input logic [1:0]  take_kind,
    input logic [15:0] vec_addr,
    input logic        busy,
    input logic        mask_x,
    input logic        mask_i,
    input logic        stack_done,
    input logic        rti
);
    logic [1:0] rec0, rec1;
    logic [1:0] rec_n;

    // Record the masks observed on each entry pulse; retire one on each honoured rti.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec0 <= '0; rec1 <= '0; rec_n <= '0;
        end else if (take) begin
            rec0 <= {mask_x, mask_i};
            rec1 <= rec0;
            if (rec_n != 2'd2) rec_n <= rec_n + 1'b1;
        end else if (rti && !busy && rec_n != 2'd0) begin
            rec0 <= rec1;
            rec1 <= '0;
            rec_n <= rec_n - 1'b1;
        end
    end

    assert_take_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take);
    assert_take_starts_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (busy && !$past(busy)));
    assert_masks_hold_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !stack_done) |=> ($stable(mask_x) && $stable(mask_i)));
    assert_nmi_sets_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && stack_done && take_kind == 2'd2) |=> (mask_x && mask_i));
    assert_irq_keeps_x_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && stack_done && take_kind == 2'd3) |=> (mask_i && mask_x == $past(mask_x)));
    assert_x_rises_only_on_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mask_x) |-> ($past(busy && stack_done) || $past(rti)));
    assert_trap_vector_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_kind == 2'd0) |-> (vec_addr == 16'hFFF8));
    assert_restore_matches_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rti && !busy && rec_n != 2'd0) |=> ({mask_x, mask_i} == $past(rec0)));
endmodule

bind exc_ctl exc_ctl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .take_kind  (take_kind),
    .vec_addr   (vec_addr),
    .busy       (busy),
    .mask_x     (mask_x),
    .mask_i     (mask_i),
    .stack_done (stack_done),
    .rti        (rti)
);

// File: tb/sim_exc_ctl.sv
// Scoreboard bench for exc_ctl: the driver queues expected entries, the monitor matches them.
module sim_exc_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 0, insn_p2 = 0, insn_swi = 0;
    logic [7:0]  insn_code = '0;
    logic [15:0] insn_pc = '0, insn_next_pc = '0;
    logic        nmi_req = 0, irq_req = 0, stack_done = 0, rti = 0;
    logic        ccr_wr = 0, ccr_wx = 0, ccr_wi = 0;
    logic        take, busy, mask_x, mask_i;
    logic [1:0]  take_kind;
    logic [15:0] vec_addr, ret_addr;

    int checks = 0;
    int errors = 0;
    int traps  = 0;

    typedef struct {
        logic [1:0]  k;
        logic [15:0] v;
        logic [15:0] r;
        string       req;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    exc_ctl u0 (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_p2(insn_p2),
        .insn_code(insn_code), .insn_swi(insn_swi), .insn_pc(insn_pc),
        .insn_next_pc(insn_next_pc), .nmi_req(nmi_req), .irq_req(irq_req),
        .stack_done(stack_done), .rti(rti), .ccr_wr(ccr_wr), .ccr_wx(ccr_wx),
        .ccr_wi(ccr_wi), .take(take), .take_kind(take_kind), .vec_addr(vec_addr),
        .ret_addr(ret_addr), .busy(busy), .mask_x(mask_x), .mask_i(mask_i)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit p2_ok(input int c);
        return ((c % 5) == 0) || c == 1 || c == 2;
    endfunction

    // Monitor: just after each edge, pop and compare on every entry pulse.
    always @(posedge clk) begin
        #2;
        if (rst_n && take) begin
            if (sb.size() == 0) begin
                check(0, "R7", "unexpected take", take_kind, 0);
            end else begin
                item_t e;
                e = sb.pop_front();
                check(take_kind == e.k, e.req, "take_kind", take_kind, e.k);
                check(vec_addr == e.v, e.req, "vec_addr", vec_addr, e.v);
                check(ret_addr == e.r, e.req, "ret_addr", ret_addr, e.r);
            end
        end
    end

    // Driver: present one boundary and queue the entry it should cause.
    task automatic boundary(input bit p2, input logic [7:0] code, input bit swi,
                            input logic [15:0] pc, input logic [15:0] nxt,
                            input bit nr, input bit ir, input bit exp,
                            input logic [1:0] k, input string req);
        item_t e;
        @(negedge clk);
        insn_valid = 1; insn_p2 = p2; insn_code = code; insn_swi = swi;
        insn_pc = pc; insn_next_pc = nxt; nmi_req = nr; irq_req = ir;
        if (exp) begin
            e.k = k;
            e.v = (k == 2'd0) ? 16'hFFF8 : (k == 2'd1) ? 16'hFFF6 :
                  (k == 2'd2) ? 16'hFFF4 : 16'hFFF2;
            e.r = (k < 2'd2) ? nxt : pc;
            e.req = req;
            sb.push_back(e);
        end
        @(negedge clk);
        insn_valid = 0; insn_p2 = 0; insn_swi = 0; nmi_req = 0; irq_req = 0;
        @(negedge clk);
        check(sb.size() == 0, req, "missing take", sb.size(), 0);
    endtask

    task automatic finish_stack();
        @(negedge clk); stack_done = 1;
        @(negedge clk); stack_done = 0;
    endtask

    task automatic do_rti();
        @(negedge clk); rti = 1;
        @(negedge clk); rti = 0;
    endtask

    task automatic wr(input bit x, input bit i);
        @(negedge clk); ccr_wr = 1; ccr_wx = x; ccr_wi = i;
        @(negedge clk); ccr_wr = 0;
    endtask

    task automatic masks(input bit x, input bit i, input string req);
        check(mask_x == x, req, "mask_x", mask_x, x);
        check(mask_i == i, req, "mask_i", mask_i, i);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        masks(1, 1, "R1");
        check(take == 0, "R1", "take", take, 0);
        check(busy == 0, "R1", "busy", busy, 0);

        // R6/R5: requests blocked by set masks
        boundary(0, 8'h00, 0, 16'h0100, 16'h0101, 0, 1, 0, 2'd3, "R6");
        boundary(0, 8'h00, 0, 16'h0100, 16'h0101, 1, 0, 0, 2'd2, "R5");

        // R8: software cannot set X
        wr(1, 0); masks(1, 0, "R8");
        wr(0, 0); masks(0, 0, "R8");
        wr(1, 0); masks(0, 0, "R8");

        // R6 maskable entry, masks held until stacking is done
        boundary(0, 8'h00, 0, 16'h1000, 16'h1001, 0, 1, 1, 2'd3, "R6");
        check(busy == 1, "R7", "busy after take", busy, 1);
        masks(0, 0, "R6");
        boundary(0, 8'h00, 1, 16'h1000, 16'h1001, 0, 0, 0, 2'd1, "R7");
        wr(0, 1); masks(0, 0, "R8");
        finish_stack(); masks(0, 1, "R6");

        // R5 nonmaskable entry nested inside the maskable service
        boundary(0, 8'h00, 0, 16'h2000, 16'h2001, 1, 0, 1, 2'd2, "R5");
        masks(0, 1, "R5");
        finish_stack(); masks(1, 1, "R5");

        // R9 unwind both levels, then an extra return
        do_rti(); masks(0, 1, "R9");
        do_rti(); masks(0, 0, "R9");
        do_rti(); masks(0, 0, "R9");

        // R3 priority among simultaneous sources
        boundary(1, 8'h07, 1, 16'h3000, 16'h3002, 1, 1, 1, 2'd0, "R3");
        finish_stack(); masks(0, 1, "R10"); do_rti();
        boundary(0, 8'h00, 1, 16'h3100, 16'h3101, 1, 1, 1, 2'd1, "R3");
        finish_stack(); masks(0, 1, "R10"); do_rti();
        boundary(0, 8'h00, 0, 16'h3200, 16'h3201, 1, 1, 1, 2'd2, "R3");
        finish_stack(); masks(1, 1, "R5");

        // R4 software interrupt with both masks set
        boundary(0, 8'h00, 1, 16'h3300, 16'h3301, 0, 0, 1, 2'd1, "R4");
        finish_stack(); masks(1, 1, "R4");
        do_rti(); do_rti(); masks(0, 0, "R9");

        // R2 sweep of all second-page codes
        for (int c = 0; c < 256; c++) begin
            bit bad;
            bad = !p2_ok(c);
            boundary(1, 8'(c), 0, 16'h4000 + 16'(c), 16'h5000 + 16'(c), 0, 0, bad, 2'd0, "R2");
            if (bad) begin
                traps++;
                finish_stack();
                do_rti();
            end
        end
        check(traps == 202, "R2", "trap count", traps, 202);
        masks(0, 0, "R9");

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule